// File: doc/BRIEF.md
# Ratio-Coincidence Sync Pulse Generator

This block divides one fast reference clock into two 50% duty clocks, `qa` and `qfb`, whose frequency ratio is picked by a two-bit select. When the ratio is fractional, the two clocks only rise together once per frame. The frame is the least common multiple of their periods. A third output, `qsync`, flags each such coincidence. It is a high pulse that starts and ends on falling edges of `qfb` and is centred on the shared rising edge. Logic downstream uses it to find the aligned clock cycle without comparing the two clocks itself.

The reference clock stands in for an oscillator. A unit parameter `HALF_UNIT` sets how many reference cycles make one time unit. In the text below, H is `HALF_UNIT`, p is the QA frequency weight and q is the QFB frequency weight. The output enable forces `qa` and `qsync` low but leaves `qfb` running, so a feedback loop that uses `qfb` is never broken. A test bypass input sends the reference clock straight to the clock outputs.

Top module: `syncgen_top`

## Requirements
- R1: While `rstN` is low, `qa`, `qfb` and `qsync` are low. On the first reference rising edge after release, `qa` and `qfb` both go high in the same cycle.
- R2: `ratioSel` encodes QA:QFB as 0 = 1:1, 1 = 1:2, 2 = 3:4 and 3 = 4:5 (p:q). `qa` stays in each level for q·H reference cycles and `qfb` for p·H reference cycles.
- R3: Coincident rising edges of `qa` and `qfb` repeat every 2·p·q·H reference cycles, counted from the first rising edge.
- R4: `qsync` rises together with the `qfb` falling edge that lies p·H cycles before a coincident rising edge. That coincident edge therefore sits at the centre of the pulse.
- R5: `qsync` falls on the next `qfb` falling edge after it rose, so the pulse lasts 2·p·H reference cycles, which is one QFB period.
- R6: With `ratioSel` = 0 (1:1), `qsync` stays low.
- R7: The coincident rising edge that starts a run, after reset or after a restart, has no `qsync` pulse.
- R8: A change of `ratioSel` restarts the block. At the reference edge where the change is seen, `qa`, `qfb` and `qsync` go low. On the next edge `qa` and `qfb` rise together under the new ratio.
- R9: While `outEn` is low, `qa` and `qsync` read low and `qfb` keeps toggling. The divider phase is not disturbed, so when `outEn` returns both outputs show their undisturbed waveform at once.
- R10: While `testBypass` is high, `qfb` equals `refClk`, `qa` equals `refClk` gated by `outEn`, and `qsync` is low. The dividers are held as in a restart, so the edge after bypass ends starts a fresh run as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioSel | input | 2 | QA:QFB ratio select (0=1:1, 1=1:2, 2=3:4, 3=4:5) |
| outEn | input | 1 | Output enable for `qa` and `qsync` |
| testBypass | input | 1 | Passes the reference clock to the outputs |
| qa | output | 1 | Divided clock, bank A |
| qfb | output | 1 | Divided feedback clock |
| qsync | output | 1 | Coincidence marker pulse |

## Verification
The restart from a ratio change can arrive on the very cycle where `qsync` is high and waiting for its closing `qfb` fall. The output enable can likewise drop in the middle of a pulse. The bench waits until it sees `qsync` high and then changes the select or drops the enable at that point. A behavioural model that counts reference cycles judges the outcome: the pulse must vanish on the restart edge, or be masked while the divider phase carries on. A monitor also measures every complete pulse for its width and for the position of the coincident edge.

// File: rtl/syncgen_pkg.sv
package syncgen_pkg;

  typedef enum logic [1:0] {
    RAT_1TO1 = 2'd0,
    RAT_1TO2 = 2'd1,
    RAT_3TO4 = 2'd2,
    RAT_4TO5 = 2'd3
  } ratio_e;

  // strobes from control to the dividers
  typedef struct packed {
    logic   restart;
    ratio_e ratio;
  } dpCtl_t;

  localparam int unsigned MAX_PRODUCT = 20;  // largest p*q over all ratios

  // frequency weight of the A bank (p)
  function automatic int unsigned freqA(ratio_e r);
    case (r)
      RAT_3TO4: return 3;
      RAT_4TO5: return 4;
      default:  return 1;
    endcase
  endfunction

  // frequency weight of the feedback bank (q)
  function automatic int unsigned freqF(ratio_e r);
    case (r)
      RAT_1TO2: return 2;
      RAT_3TO4: return 4;
      RAT_4TO5: return 5;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/syncgen_div.sv
module syncgen_div
  import syncgen_pkg::*;
#(
  parameter int unsigned HALF_UNIT = 1,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  output logic             qaDiv,
  output logic             qfbDiv,
  output logic             running,
  output logic [CNT_W-1:0] frame
);

  localparam int NUM_BANKS = 2;  // index 0 = A bank, 1 = feedback bank

  logic [CNT_W-1:0] halfLast [NUM_BANKS];
  logic [CNT_W-1:0] frameLast;
  logic [NUM_BANKS-1:0] bankQ;

  // a bank's half period follows the other bank's frequency weight
  always_comb begin
    halfLast[0] = CNT_W'(freqF(ctl.ratio) * HALF_UNIT - 1);
    halfLast[1] = CNT_W'(freqA(ctl.ratio) * HALF_UNIT - 1);
    frameLast   = CNT_W'(2 * freqA(ctl.ratio) * freqF(ctl.ratio) * HALF_UNIT - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            running <= 1'b0;
    else if (ctl.restart) running <= 1'b0;
    else                  running <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] halfCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        halfCnt  <= '0;
        bankQ[b] <= 1'b0;
      end else if (ctl.restart) begin
        halfCnt  <= '0;
        bankQ[b] <= 1'b0;
      end else if (!running) begin
        halfCnt  <= '0;      // aligned launch: both banks rise here
        bankQ[b] <= 1'b1;
      end else if (halfCnt == halfLast[b]) begin
        halfCnt  <= '0;
        bankQ[b] <= ~bankQ[b];
      end else begin
        halfCnt  <= halfCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  frame <= '0;
    else if (ctl.restart)       frame <= '0;
    else if (!running)          frame <= '0;
    else if (frame == frameLast) frame <= '0;
    else                        frame <= frame + 1'b1;
  end

  assign qaDiv  = bankQ[0];
  assign qfbDiv = bankQ[1];

  // R3: a joint rising edge only ever happens at the start of a frame
  p_coincide_at_frame_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(qaDiv) && $rose(qfbDiv)) |-> (frame == '0));

  // R8: a restart leaves both clocks low and the dividers idle
  p_restart_idles_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> (!qaDiv && !qfbDiv && !running));

endmodule

// File: rtl/syncgen_ctl.sv
module syncgen_ctl
  import syncgen_pkg::*;
#(
  parameter int unsigned HALF_UNIT = 1,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       ratioSel,
  input  logic             bypass,
  input  logic             running,
  input  logic [CNT_W-1:0] frame,
  output dpCtl_t           ctl,
  output logic             qsyncR
);

  ratio_e           selQ;
  ratio_e           selNew;
  logic [CNT_W-1:0] setAt;
  logic [CNT_W-1:0] clrAt;
  logic             syncEn;

  assign selNew = ratio_e'(ratioSel);

  always_comb begin
    ctl.restart = bypass || (selNew != selQ);
    ctl.ratio   = selNew;
  end

  // set on the QFB fall half a QFB period before the frame wraps,
  // clear on the QFB fall half a period after it
  always_comb begin
    setAt  = CNT_W'(2 * freqA(selQ) * freqF(selQ) * HALF_UNIT - freqA(selQ) * HALF_UNIT - 1);
    clrAt  = CNT_W'(freqA(selQ) * HALF_UNIT - 1);
    syncEn = (selQ != RAT_1TO1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= RAT_1TO1;
    else       selQ <= selNew;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  qsyncR <= 1'b0;
    else if (ctl.restart)                       qsyncR <= 1'b0;
    else if (running && syncEn && frame == setAt) qsyncR <= 1'b1;
    else if (running && frame == clrAt)         qsyncR <= 1'b0;
  end

  // R6: no pulse while the ratio is an integer 1:1
  p_quiet_when_integer_r6: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == RAT_1TO1) |-> !qsyncR);

endmodule

// File: rtl/syncgen_top.sv
module syncgen_top
  import syncgen_pkg::*;
#(
  parameter int unsigned HALF_UNIT = 1
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic [1:0] ratioSel,
  input  logic       outEn,
  input  logic       testBypass,
  output logic       qa,
  output logic       qfb,
  output logic       qsync
);

  localparam int unsigned FRAME_MAX = 2 * MAX_PRODUCT * HALF_UNIT;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX);

  dpCtl_t           ctl;
  logic             qaDiv;
  logic             qfbDiv;
  logic             running;
  logic             qsyncR;
  logic [CNT_W-1:0] frame;

  syncgen_ctl #(.HALF_UNIT(HALF_UNIT), .CNT_W(CNT_W)) i_ctl (
    .clk     (refClk),
    .rstN    (rstN),
    .ratioSel(ratioSel),
    .bypass  (testBypass),
    .running (running),
    .frame   (frame),
    .ctl     (ctl),
    .qsyncR  (qsyncR)
  );

  syncgen_div #(.HALF_UNIT(HALF_UNIT), .CNT_W(CNT_W)) i_div (
    .clk    (refClk),
    .rstN   (rstN),
    .ctl    (ctl),
    .qaDiv  (qaDiv),
    .qfbDiv (qfbDiv),
    .running(running),
    .frame  (frame)
  );

  assign qa    = outEn & (testBypass ? refClk : qaDiv);
  assign qfb   = testBypass ? refClk : qfbDiv;
  assign qsync = outEn & ~testBypass & qsyncR;

  // R4: the pulse opens only together with a QFB falling edge
  p_sync_rise_on_fb_fall_r4: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(qsyncR) |-> $fell(qfbDiv));

  // R5: unless a restart cut it short, the pulse closes on a QFB falling edge
  p_sync_fall_on_fb_fall_r5: assert property (@(posedge refClk) disable iff (!rstN)
    ($fell(qsyncR) && !$past(ctl.restart)) |-> $fell(qfbDiv));

endmodule

// File: tb/test_syncgen_top.sv
module test_syncgen_top;

  localparam int H = 1;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] ratioSel;
  logic       outEn;
  logic       testBypass;
  logic       qa, qfb, qsync;

  always #4 clk = ~clk;  // 125 MHz

  syncgen_top #(.HALF_UNIT(H)) i_syncgen_top (
    .refClk(clk), .rstN(rstN), .ratioSel(ratioSel), .outEn(outEn),
    .testBypass(testBypass), .qa(qa), .qfb(qfb), .qsync(qsync)
  );

  int    checks = 0;
  int    errors = 0;
  string tag    = "R1";
  bit    started = 0;

  // behavioural model state
  int t = -1;        // cycles since the aligned launch, -1 when idle
  int mSel = 0;
  int cyc = 0;

  // pulse monitor state
  int riseT = -1;
  int coinT = -1;
  logic pQa = 0, pQfb = 0, pQs = 0;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic checkInt(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic int wA(input int s);  // QA frequency weight p
    case (s) 2: return 3; 3: return 4; default: return 1; endcase
  endfunction
  function automatic int wF(input int s);  // QFB frequency weight q
    case (s) 1: return 2; 2: return 4; 3: return 5; default: return 1; endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (started) begin
      int p, q, f, k;
      logic eQa, eQfb, eQs;
      cyc++;
      if (!rstN) begin
        t = -1; mSel = 0;
      end else if (testBypass || (int'(ratioSel) != mSel)) begin
        t = -1; mSel = int'(ratioSel);
      end else begin
        t++;
      end
      p = wA(mSel); q = wF(mSel); f = 2 * p * q * H;
      if (t < 0) begin
        eQa = 0; eQfb = 0; eQs = 0;
      end else begin
        k    = t % f;
        eQa  = (k % (2 * q * H)) < q * H;
        eQfb = (k % (2 * p * H)) < p * H;
        eQs  = (mSel != 0) && ((k >= f - p * H) || (k < p * H && t >= f));
      end
      if (testBypass) begin
        eQa = outEn; eQfb = 1'b1; eQs = 1'b0;  // clk is high here
      end else begin
        eQa = eQa & outEn; eQs = eQs & outEn;
      end
      check(tag, "qa", qa, eQa);
      check(tag, "qfb", qfb, eQfb);
      check(tag, "qsync", qsync, eQs);

      // pulse monitor on observed outputs
      if (!rstN || testBypass || !outEn || t < 0) begin
        riseT = -1; coinT = -1;
      end else begin
        if (qa && !pQa && qfb && !pQfb) coinT = cyc;
        if (qsync && !pQs) riseT = cyc;
        if (!qsync && pQs && riseT >= 0) begin
          checkInt("R5", "pulse width", cyc - riseT, 2 * p * H);
          checkInt("R4", "coincidence offset in pulse", coinT - riseT, p * H);
          riseT = -1;
        end
      end
      pQa = qa; pQfb = qfb; pQs = qsync;
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  task automatic waitPulse();
    while (!qsync) @(negedge clk);
  endtask

  initial begin
    rstN = 0; ratioSel = 2'd0; outEn = 1; testBypass = 0;
    @(negedge clk);
    started = 1;
    tag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    tag = "R6";                       // 1:1, no pulse
    repeat (20) @(negedge clk);
    ratioSel = 2'd1; tag = "R2/R7";   // 1:2
    repeat (30) @(negedge clk);
    ratioSel = 2'd2; tag = "R3/R4/R5";// 3:4
    repeat (80) @(negedge clk);
    ratioSel = 2'd3;                  // 4:5
    repeat (120) @(negedge clk);
    waitPulse();
    ratioSel = 2'd2; tag = "R8";      // restart in the middle of a pulse
    repeat (70) @(negedge clk);
    waitPulse();
    outEn = 0; tag = "R9";            // mask in the middle of a pulse
    repeat (30) @(negedge clk);
    outEn = 1;
    repeat (60) @(negedge clk);
    testBypass = 1; tag = "R10";
    repeat (4) @(negedge clk);
    #2;
    check("R10", "qfb low phase", qfb, 1'b0);
    check("R10", "qa low phase", qa, 1'b0);
    outEn = 0;
    @(posedge clk); #3;
    check("R10", "qa masked", qa, 1'b0);
    check("R10", "qfb passes clock", qfb, 1'b1);
    @(negedge clk);
    outEn = 1;
    @(negedge clk);
    testBypass = 0;
    repeat (60) @(negedge clk);
    ratioSel = 2'd0; tag = "R6";
    repeat (30) @(negedge clk);
    ratioSel = 2'd3; tag = "R1";
    repeat (50) @(negedge clk);
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1; ratioSel = 2'd1;
    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule